// File: doc/BRIEF.md
# Split Two-Way Translation Lookaside Buffer

This block caches virtual-to-physical page translations for 4 KiB pages. It holds two independent arrays: one used only by instruction fetches and one used by every other access. Each array has `SETS` sets of two ways. Each entry holds a page tag, a physical page number, a pointer to the page-table group the translation came from, an invalid flag, a most-recently-used (MRU) flag and a changed bit. A lookup presents a virtual address and an access kind. One cycle later a registered response gives hit, way, physical address and page-table-group pointer.

A page-table walker sits outside the block and loads translations through a single-cycle refill port. A refill goes to the way of the set that is not marked most recently used. A page-invalidate command wipes both ways of the indexed set in both arrays, whatever their tags are. Probe lookups translate without disturbing the replacement state. A write that hits an entry whose changed bit is still clear is reported as a miss, so the walker can go and mark the page as modified.

The response path is a small state machine with four named states. `RSP_IDLE` means no lookup happened in the previous cycle. `RSP_HIT` means a translation was found. `RSP_MISS` means no valid way matched. `RSP_CLEAN_WR` means a write found a matching entry whose changed bit is clear. The next state is chosen every cycle from the current lookup, so any state can move to any other state. The transitions are:
- no request goes to IDLE;
- a valid match that is not a clean write goes to HIT;
- a clean-entry write goes to CLEAN_WR;
- everything else goes to MISS.

Top module: `split_tlb`

## Requirements
- R1: After reset every entry of both arrays is invalid and holds a zero tag, physical page and group pointer. Any lookup, including one whose tag is zero, misses, and `rsp_valid` stays 0 until a lookup is issued.
- R2: A lookup sampled at a rising edge produces `rsp_valid`=1 from that edge until the next one; with no lookup `rsp_valid` is 0. Whenever `rsp_hit` is 0, `rsp_paddr`, `rsp_pteg` and `rsp_way` are 0.
- R3: The tag is `vaddr[31:12]` and the set index is `vaddr[17:12]`. On a hit, `rsp_paddr` = {stored physical page, `vaddr[11:0]`} and `rsp_pteg` is the stored group pointer.
- R4: `lk_kind` encodes 0 = fetch, 1 = read, 2 = write, 3 = probe. Fetches use only the instruction array. Kinds 1 to 3 use only the data array. `fill_inst`=1 loads the instruction array and 0 loads the data array.
- R5: A way hits only when its tag matches and its invalid flag is clear. Way 0 is examined before way 1, and `rsp_way` names the hitting way.
- R6: A hit by a fetch, read or write marks the hitting way MRU and clears MRU on the other way of that set. A probe hit leaves both MRU flags unchanged.
- R7: A write lookup whose matching entry has its changed bit clear responds with `rsp_hit`=0 and physical address 0, and it does not alter the MRU flags.
- R8: An invalidate sets the invalid flag on both ways of set `inv_vaddr[17:12]` in both arrays, without comparing tags. Other sets are untouched.
- R9: A refill writes the way that is not MRU, choosing way 0 when neither is. It clears that way's invalid flag, marks it MRU and clears MRU on the other way.
- R10: A refill with `fill_write`=1 stores the changed bit set, so later write lookups to it hit. With `fill_write`=0 the changed bit is stored clear.
- R11: When an invalidate and a refill address the same set of the refill's array in the same cycle, the refill is discarded. If they address different sets, both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 probe |
| lk_vaddr | input | 32 | Lookup virtual address |
| fill_valid | input | 1 | Refill request this cycle |
| fill_inst | input | 1 | Refill targets the instruction array |
| fill_write | input | 1 | Refill is for a write; stores the changed bit set |
| fill_vaddr | input | 32 | Virtual address of the page being loaded |
| fill_ppn | input | 20 | Physical page number to store |
| fill_pteg | input | 16 | Page-table-group pointer to store |
| inv_valid | input | 1 | Page-invalidate request this cycle |
| inv_vaddr | input | 32 | Address whose set is invalidated |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_way | output | 1 | Way that hit |
| rsp_paddr | output | 32 | Translated physical address, 0 on miss |
| rsp_pteg | output | 16 | Group pointer of the hit entry, 0 on miss |

## Verification
Some rules are checked on every cycle:
- each lookup gets a response in the following cycle, and an idle cycle gets none;
- a miss drives zero address and pointer;
- a hit passes the page offset through unchanged;
- a lookup issued just after an invalidate of its set misses.

Only the bench scenarios can show the replacement behaviour, because MRU state is visible only through which way a later refill overwrites. These scenarios cover:
- a probe leaving MRU unchanged while a read moves it;
- a clean-entry write leaving the victim choice alone;
- tag-blind invalidation reaching the instruction array;
- the invalidate-over-refill priority.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int PPN_W  = 20;
    localparam int PTEG_W = 16;
    localparam int TAG_W  = VA_W - OFS_W;
    localparam int PA_W   = PPN_W + OFS_W;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_PROBE = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RSP_IDLE     = 2'd0,
        RSP_HIT      = 2'd1,
        RSP_MISS     = 2'd2,
        RSP_CLEAN_WR = 2'd3
    } rsp_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PTEG_W-1:0] pteg;
        logic              invalid;
        logic              mru;
        logic              changed;
    } tlb_ent_t;
endpackage

// File: rtl/tlb_bank.sv
module tlb_bank import split_tlb_pkg::*; #(
    parameter int SETS  = 64,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output tlb_ent_t          rd_ent0,
    output tlb_ent_t          rd_ent1,
    input  logic              touch_en,
    input  logic              touch_way,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PTEG_W-1:0] fill_pteg,
    input  logic              fill_chg,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    tlb_ent_t ent_q [SETS][2];

    logic fill_do;
    logic victim;

    // invalidate to the same set suppresses the refill
    assign fill_do = fill_en && !(inv_en && (inv_idx == fill_idx));
    // way 0 unless way 0 is the most recently used
    assign victim  = ent_q[fill_idx][0].mru;

    assign rd_ent0 = ent_q[rd_idx][0];
    assign rd_ent1 = ent_q[rd_idx][1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < 2; w++) begin
                    ent_q[s][w] <= '{tag: '0, ppn: '0, pteg: '0,
                                     invalid: 1'b1, mru: 1'b0, changed: 1'b0};
                end
            end
        end else begin
            if (touch_en) begin
                ent_q[rd_idx][touch_way].mru  <= 1'b1;
                ent_q[rd_idx][!touch_way].mru <= 1'b0;
            end
            if (fill_do) begin
                ent_q[fill_idx][victim] <= '{tag: fill_tag, ppn: fill_ppn,
                                             pteg: fill_pteg, invalid: 1'b0,
                                             mru: 1'b1, changed: fill_chg};
                ent_q[fill_idx][!victim].mru <= 1'b0;
            end
            if (inv_en) begin
                ent_q[inv_idx][0].invalid <= 1'b1;
                ent_q[inv_idx][1].invalid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match import split_tlb_pkg::*; (
    input  tlb_ent_t          ent0,
    input  tlb_ent_t          ent1,
    input  logic [TAG_W-1:0]  tag,
    input  acc_e              kind,
    output logic              hit,
    output logic              clean_wr,
    output logic              way,
    output logic              touch,
    output logic [PPN_W-1:0]  ppn,
    output logic [PTEG_W-1:0] pteg
);
    logic     m0, m1, any;
    tlb_ent_t sel;

    always_comb begin
        m0       = (ent0.tag == tag) && !ent0.invalid;
        m1       = (ent1.tag == tag) && !ent1.invalid;
        any      = m0 || m1;
        way      = !m0;
        sel      = m0 ? ent0 : ent1;
        clean_wr = any && (kind == ACC_WRITE) && !sel.changed;
        hit      = any && !clean_wr;
        touch    = hit && (kind != ACC_PROBE);
        ppn      = sel.ppn;
        pteg     = sel.pteg;
    end
endmodule

// File: rtl/split_tlb.sv
module split_tlb import split_tlb_pkg::*; #(
    parameter int SETS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [1:0]        lk_kind,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              fill_valid,
    input  logic              fill_inst,
    input  logic              fill_write,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PTEG_W-1:0] fill_pteg,
    input  logic              inv_valid,
    input  logic [VA_W-1:0]   inv_vaddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_way,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [PTEG_W-1:0] rsp_pteg
);
    localparam int IDX_W = $clog2(SETS);
    localparam int NBANK = 2;   // 0: data, 1: instruction

    acc_e             kind;
    logic             is_fetch;
    logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx;
    logic [TAG_W-1:0] lk_tag;

    assign kind     = acc_e'(lk_kind);
    assign is_fetch = (kind == ACC_FETCH);
    assign lk_tag   = lk_vaddr[VA_W-1:OFS_W];
    assign lk_idx   = lk_vaddr[OFS_W +: IDX_W];
    assign fill_idx = fill_vaddr[OFS_W +: IDX_W];
    assign inv_idx  = inv_vaddr[OFS_W +: IDX_W];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{fill_vaddr[OFS_W-1:0], inv_vaddr[VA_W-1:OFS_W+IDX_W],
                                inv_vaddr[OFS_W-1:0]};

    tlb_ent_t bank_e0 [NBANK];
    tlb_ent_t bank_e1 [NBANK];
    logic     m_hit, m_clean, m_way, m_touch;
    logic [PPN_W-1:0]  m_ppn;
    logic [PTEG_W-1:0] m_pteg;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sel_lk, sel_fill;
        assign sel_lk   = (is_fetch == (g == 1));
        assign sel_fill = (fill_inst == (g == 1));

        tlb_bank #(.SETS(SETS), .IDX_W(IDX_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (lk_idx),
            .rd_ent0   (bank_e0[g]),
            .rd_ent1   (bank_e1[g]),
            .touch_en  (lk_valid && m_touch && sel_lk),
            .touch_way (m_way),
            .fill_en   (fill_valid && sel_fill),
            .fill_idx  (fill_idx),
            .fill_tag  (fill_vaddr[VA_W-1:OFS_W]),
            .fill_ppn  (fill_ppn),
            .fill_pteg (fill_pteg),
            .fill_chg  (fill_write),
            .inv_en    (inv_valid),
            .inv_idx   (inv_idx)
        );
    end

    tlb_match match_i (
        .ent0     (is_fetch ? bank_e0[1] : bank_e0[0]),
        .ent1     (is_fetch ? bank_e1[1] : bank_e1[0]),
        .tag      (lk_tag),
        .kind     (kind),
        .hit      (m_hit),
        .clean_wr (m_clean),
        .way      (m_way),
        .touch    (m_touch),
        .ppn      (m_ppn),
        .pteg     (m_pteg)
    );

    // response state machine
    rsp_e              state_q, state_d;
    logic              way_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PTEG_W-1:0] pteg_q;
    logic [OFS_W-1:0]  ofs_q;

    always_comb begin
        if (!lk_valid)     state_d = RSP_IDLE;
        else if (m_hit)    state_d = RSP_HIT;
        else if (m_clean)  state_d = RSP_CLEAN_WR;
        else               state_d = RSP_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            way_q   <= 1'b0;
            ppn_q   <= '0;
            pteg_q  <= '0;
            ofs_q   <= '0;
        end else begin
            state_q <= state_d;
            way_q   <= m_way;
            ppn_q   <= m_ppn;
            pteg_q  <= m_pteg;
            ofs_q   <= lk_vaddr[OFS_W-1:0];
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_way   = 1'b0;
        rsp_paddr = '0;
        rsp_pteg  = '0;
        unique case (state_q)
            RSP_IDLE: begin
            end
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_way   = way_q;
                rsp_paddr = {ppn_q, ofs_q};
                rsp_pteg  = pteg_q;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
            end
            RSP_CLEAN_WR: begin
                rsp_valid = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk import split_tlb_pkg::*; #(
    parameter int SETS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              inv_valid,
    input logic [VA_W-1:0]   inv_vaddr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_way,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [PTEG_W-1:0] rsp_pteg
);
    localparam int IDX_W = $clog2(SETS);

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r2_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0 && rsp_pteg == '0 && !rsp_way));

    a_r2_hit_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    a_r3_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

    a_r8_inv_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_valid) && lk_valid &&
         lk_vaddr[OFS_W +: IDX_W] == $past(inv_vaddr[OFS_W +: IDX_W])) |=> !rsp_hit);
endmodule

bind split_tlb split_tlb_chk #(.SETS(SETS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .inv_valid (inv_valid),
    .inv_vaddr (inv_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .rsp_paddr (rsp_paddr),
    .rsp_pteg  (rsp_pteg)
);

// File: tb/split_tlb_tb_top.sv
module split_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_kind = 2'd0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0, fill_inst = 1'b0, fill_write = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [19:0] fill_ppn = '0;
    logic [15:0] fill_pteg = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_way;
    logic [31:0] rsp_paddr;
    logic [15:0] rsp_pteg;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    split_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_inst(fill_inst), .fill_write(fill_write),
        .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn), .fill_pteg(fill_pteg),
        .inv_valid(inv_valid), .inv_vaddr(inv_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_paddr(rsp_paddr), .rsp_pteg(rsp_pteg)
    );

    localparam logic [1:0] K_FETCH = 2'd0, K_READ = 2'd1, K_WRITE = 2'd2, K_PROBE = 2'd3;

    function automatic logic [31:0] va(int t, int s, int off);
        return {14'(t), 6'(s), 12'(off)};
    endfunction
    function automatic logic [19:0] ppn_of(int t, int s);
        return 20'(t * 1000 + s * 7 + 3);
    endfunction
    function automatic logic [15:0] pteg_of(int t, int s);
        return 16'(t * 64 + s);
    endfunction
    function automatic int off_of(int s);
        return (s * 37 + 5) % 4096;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input bit inst, input bit wr, input int t, input int s);
        @(negedge clk);
        fill_valid = 1'b1; fill_inst = inst; fill_write = wr;
        fill_vaddr = va(t, s, 0); fill_ppn = ppn_of(t, s); fill_pteg = pteg_of(t, s);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic inval(input int t, input int s);
        @(negedge clk);
        inv_valid = 1'b1; inv_vaddr = va(t, s, 123);
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    // lookup: response registered at the next rising edge, checked at the following falling edge
    task automatic look(input string req, input logic [1:0] k, input int t, input int s,
                        input bit exp_hit, input bit exp_way);
        int off;
        off = off_of(s);
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = k; lk_vaddr = va(t, s, off);
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'(1));
        check({req, " rsp_hit"}, 64'(rsp_hit), 64'(exp_hit));
        check({req, " rsp_paddr"}, 64'(rsp_paddr),
              exp_hit ? 64'({ppn_of(t, s), 12'(off)}) : 64'(0));
        if (exp_hit) begin
            check({req, " rsp_way"}, 64'(rsp_way), 64'(exp_way));
            check({req, " rsp_pteg"}, 64'(rsp_pteg), 64'(pteg_of(t, s)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'(0));

        // R1: every set of both arrays empty, including the all-zero tag
        for (int s = 0; s < 64; s++) begin
            look("R1 data empty", K_READ, 0, s, 1'b0, 1'b0);
            look("R1 inst empty", K_FETCH, 0, s, 1'b0, 1'b0);
        end
        @(negedge clk);
        check("R2 idle no response", 64'(rsp_valid), 64'(0));

        // R9 R10: fill both ways of every data set for writes
        for (int s = 0; s < 64; s++) begin
            fill(1'b0, 1'b1, 1, s);
            fill(1'b0, 1'b1, 2, s);
        end
        for (int s = 0; s < 64; s++) begin
            look("R3 R9 way0 read", K_READ, 1, s, 1'b1, 1'b0);
            look("R5 R9 way1 write", K_WRITE, 2, s, 1'b1, 1'b1);
            look("R4 fetch misses data", K_FETCH, 1, s, 1'b0, 1'b0);
        end
        // all sets: MRU now way1 (last write hit)

        // R6: read moves MRU, probe does not
        look("R6 read tag1", K_READ, 1, 5, 1'b1, 1'b0);    // MRU -> way0
        fill(1'b0, 1'b1, 3, 5);                           // replaces way1
        look("R9 old way1 gone", K_READ, 2, 5, 1'b0, 1'b0);
        look("R9 new in way1", K_READ, 3, 5, 1'b1, 1'b1); // MRU -> way1
        look("R6 read tag1 again", K_READ, 1, 5, 1'b1, 1'b0); // MRU -> way0
        look("R6 probe way1", K_PROBE, 3, 5, 1'b1, 1'b1); // MRU stays way0
        fill(1'b0, 1'b1, 4, 5);                           // must replace way1
        look("R6 probe left way0 MRU", K_READ, 3, 5, 1'b0, 1'b0);
        look("R6 new fill way1", K_READ, 4, 5, 1'b1, 1'b1);
        look("R6 way0 kept", K_READ, 1, 5, 1'b1, 1'b0);

        // R7 R10: clean entry write
        fill(1'b0, 1'b0, 5, 9);                           // MRU was way1 -> way0
        look("R10 clean read hits", K_READ, 5, 9, 1'b1, 1'b0);
        look("R6 read way1", K_READ, 2, 9, 1'b1, 1'b1);   // MRU -> way1
        look("R7 clean write miss", K_WRITE, 5, 9, 1'b0, 1'b0);
        fill(1'b0, 1'b1, 6, 9);                           // must go to way0
        look("R7 no MRU update", K_READ, 5, 9, 1'b0, 1'b0);
        look("R7 victim way0", K_READ, 6, 9, 1'b1, 1'b0);
        look("R7 way1 kept", K_READ, 2, 9, 1'b1, 1'b1);
        look("R10 dirty write hit", K_WRITE, 6, 9, 1'b1, 1'b0);

        // R4: instruction array
        fill(1'b1, 1'b0, 7, 3);
        look("R4 fetch inst hit", K_FETCH, 7, 3, 1'b1, 1'b0);
        look("R4 read misses inst", K_READ, 7, 3, 1'b0, 1'b0);
        look("R4 probe misses inst", K_PROBE, 7, 3, 1'b0, 1'b0);
        look("R4 data set 3 intact", K_READ, 1, 3, 1'b1, 1'b0);

        // R8: tag-blind invalidate of set 3 in both arrays
        inval(8, 3);
        look("R8 inst way0 gone", K_FETCH, 7, 3, 1'b0, 1'b0);
        look("R8 data way0 gone", K_READ, 1, 3, 1'b0, 1'b0);
        look("R8 data way1 gone", K_READ, 2, 3, 1'b0, 1'b0);
        look("R8 other set kept", K_READ, 1, 4, 1'b1, 1'b0);
        look("R8 other set way1 kept", K_READ, 2, 2, 1'b1, 1'b1);

        // R11: same-set invalidate beats refill
        @(negedge clk);
        inv_valid = 1'b1; inv_vaddr = va(0, 20, 0);
        fill_valid = 1'b1; fill_inst = 1'b0; fill_write = 1'b1;
        fill_vaddr = va(9, 20, 0); fill_ppn = ppn_of(9, 20); fill_pteg = pteg_of(9, 20);
        @(negedge clk);
        inv_valid = 1'b0; fill_valid = 1'b0;
        look("R11 fill dropped", K_READ, 9, 20, 1'b0, 1'b0);
        look("R11 set20 way0 invalid", K_READ, 1, 20, 1'b0, 1'b0);
        look("R11 set20 way1 invalid", K_READ, 2, 20, 1'b0, 1'b0);

        // R11: different sets both act
        @(negedge clk);
        inv_valid = 1'b1; inv_vaddr = va(0, 21, 0);
        fill_valid = 1'b1; fill_inst = 1'b0; fill_write = 1'b1;
        fill_vaddr = va(10, 22, 0); fill_ppn = ppn_of(10, 22); fill_pteg = pteg_of(10, 22);
        @(negedge clk);
        inv_valid = 1'b0; fill_valid = 1'b0;
        look("R11 set21 invalid", K_READ, 1, 21, 1'b0, 1'b0);
        look("R11 fill set22 way0", K_READ, 10, 22, 1'b1, 1'b0);
        look("R11 set22 way1 kept", K_READ, 2, 22, 1'b1, 1'b1);

        @(negedge clk);
        check("R2 final idle", 64'(rsp_valid), 64'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule